// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address sequence of a four-beat burst for a synchronous burst memory. An external address is captured when a strobe is seen. There are two strobes, both active low. The processor strobe counts only while the device select input is high. The cache strobe loads whether or not the device is selected. After a load, every clock edge with the active-low advance input asserted steps the two least significant address bits to the next beat. The upper address bits keep the value that was loaded.

The ordering of the low bits is set by a mode input. In linear mode the low bits are a wrapping increment from the loaded value. In interleaved mode they are the loaded low bits XOR a beat counter. The mode input is registered, so a change on it reaches the address one clock later. The block presents the full current address and the beat index, counted 0 to 3.

The control is a two-state machine. `BS_IDLE` is the state after reset, and in it the advance input has no effect. `BS_BURST` is entered from either state by a load. The machine stays in `BS_BURST` until reset, and any further load restarts the burst from beat 0. The transitions are: reset to `BS_IDLE`; load, from either state, to `BS_BURST` at beat 0; advance in `BS_BURST`, which stays in `BS_BURST` and steps the beat; and hold, in either state, with nothing changed.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addr_out` is 0, `beat` is 0 and the machine is in `BS_IDLE`, where an asserted advance leaves both outputs at 0.
- R2: An edge with `adsc_n`=0 loads `addr_in` whatever the level of `sel`. After that edge, `addr_out` equals `addr_in` and `beat` is 0.
- R3: An edge with `adsp_n`=0 and `sel`=1 loads `addr_in` in the same way as R2. With `sel`=0 and `adsc_n`=1, `adsp_n`=0 leaves the address and the beat unchanged.
- R4: When both strobes are asserted at the same edge, the block performs one load of `addr_in`.
- R5: A load takes priority over an advance at the same edge, so the beat becomes 0.
- R6: In `BS_BURST`, `beat` steps by one at each edge with `adv_n`=0 and no load. At an edge with `adv_n`=1 and no load, `beat` and the address stay as they are.
- R7: With `mode_lin`=1 (linear ordering), the low two bits of `addr_out` equal (loaded low bits + `beat`) mod 4.
- R8: With `mode_lin`=0 (interleaved ordering), the low two bits of `addr_out` equal the loaded low bits XOR `beat`.
- R9: Between loads, the bits of `addr_out` above bit 1 stay equal to the loaded address.
- R10: An advance after beat 3 wraps `beat` to 0 and returns `addr_out` to the loaded address.
- R11: `mode_lin` is sampled at each rising edge. A change on it alters the ordering only after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, applied synchronously at the edge |
| sel | input | 1 | Device select; 1 lets the processor strobe load |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Cache address strobe, active low |
| adv_n | input | 1 | Advance to the next beat, active low |
| mode_lin | input | 1 | 1 selects linear ordering, 0 selects interleaved ordering |
| addr_in | input | ADDR_W | Address captured on a load |
| addr_out | output | ADDR_W | Current burst address |
| beat | output | 2 | Beat index 0 to 3 |

## Verification
The embedded properties check the following on every cycle:
- a load clears the beat and captures the input address;
- an advance steps the beat by one, and an edge with no advance changes nothing;
- a processor strobe while deselected has no effect;
- the idle state ignores advances;
- the upper address bits do not move between loads;
- beat 0 always presents the loaded address.

The properties do not cover everything. The exact low-bit sequences of the two orderings, the wrap back to the first address, and the one-clock lag of a mode change can only be shown by the bench scenarios, which compare the outputs with sequences worked out by hand from the requirements.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic {
        BS_IDLE  = 1'b0,
        BS_BURST = 1'b1
    } bs_state_e;

endpackage

// File: rtl/bsq_order.sv
module bsq_order
    import burst_seq_pkg::*;
(
    input  logic [BEAT_W-1:0] base_lo,
    input  logic [BEAT_W-1:0] beat,
    input  logic              lin_sel,
    output logic [BEAT_W-1:0] lo_out
);

    logic [BEAT_W-1:0] lin_lo;
    logic [BEAT_W-1:0] ilv_lo;

    // linear: wrapping add; interleaved: bitwise toggle by the beat index
    always_comb begin
        lin_lo = base_lo + beat;
        ilv_lo = base_lo ^ beat;
        lo_out = lin_sel ? lin_lo : ilv_lo;
    end

endmodule

// File: rtl/bsq_ctrl.sv
module bsq_ctrl
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base_q,
    output logic [BEAT_W-1:0] beat_q,
    output logic              load_o
);

    bs_state_e state_q;
    bs_state_e state_d;
    logic      load_w;
    logic      step_w;

    // cache strobe always loads; processor strobe only when selected
    assign load_w = !adsc_n || (!adsp_n && sel);
    assign load_o = load_w;

    always_comb begin
        state_d = state_q;
        step_w  = 1'b0;
        unique case (state_q)
            BS_IDLE: begin
                if (load_w) state_d = BS_BURST;
            end
            BS_BURST: begin
                step_w = !load_w && !adv_n;
            end
            default: state_d = BS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BS_IDLE;
        else        state_q <= state_d;
    end

    // address and beat registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
        end else if (load_w) begin
            base_q <= addr_in;
            beat_q <= '0;
        end else if (step_w) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    p_load_captures_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_w |=> (beat_q == '0) && (base_q == $past(addr_in)));

    p_advance_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BS_BURST && !load_w && !adv_n)
            |=> beat_q == $past(beat_q) + 1'b1);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_w && adv_n) |=> $stable(beat_q) && $stable(base_q));

    p_deselected_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adsc_n && !adsp_n && !sel && adv_n)
            |=> $stable(base_q) && $stable(beat_q));

    p_idle_no_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BS_IDLE && !load_w) |=> beat_q == '0);

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic              mode_lin,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [1:0]        beat
);

    localparam int HI_W = ADDR_W - BEAT_W;

    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] lo_w;
    logic              load_w;
    logic              mode_q;

    bsq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .adsp_n  (adsp_n),
        .adsc_n  (adsc_n),
        .adv_n   (adv_n),
        .addr_in (addr_in),
        .base_q  (base_q),
        .beat_q  (beat_q),
        .load_o  (load_w)
    );

    // ordering select is registered: one clock of latency on a change
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= mode_lin;
    end

    bsq_order u_order (
        .base_lo (base_q[BEAT_W-1:0]),
        .beat    (beat_q),
        .lin_sel (mode_q),
        .lo_out  (lo_w)
    );

    assign addr_out = {base_q[ADDR_W-1:BEAT_W], lo_w};
    assign beat     = beat_q;

    p_upper_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_w |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

    p_first_beat_is_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (beat == '0) |-> addr_out == base_q);

    initial begin
        assert (HI_W >= 0);
    end

endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

    localparam int AW = 12;
    localparam int NV = 14;

    typedef struct packed {
        logic          adsp_n;
        logic          adsc_n;
        logic          sel;
        logic          adv_n;
        logic          mode;
        logic [AW-1:0] addr;
        logic [AW-1:0] exp_addr;
        logic [1:0]    exp_beat;
        logic [7:0]    req;
    } vec_t;

    // adsp_n adsc_n sel adv_n mode addr exp_addr exp_beat req
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 12'h342, 12'h342, 2'd0, 8'd2},  // R2 cache strobe, deselected
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 12'h000, 12'h343, 2'd1, 8'd7},  // R7 linear
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 12'h000, 12'h340, 2'd2, 8'd9},  // R9 upper fixed
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 12'h000, 12'h340, 2'd2, 8'd6},  // R6 hold
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 12'h000, 12'h341, 2'd3, 8'd7},  // R7
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 12'h000, 12'h342, 2'd0, 8'd10}, // R10 wrap
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 12'h5A1, 12'h5A1, 2'd0, 8'd3},  // R3 processor strobe
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 12'h000, 12'h5A0, 2'd1, 8'd8},  // R8 interleaved
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 12'h000, 12'h5A3, 2'd2, 8'd8},  // R8
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 12'h000, 12'h5A2, 2'd3, 8'd8},  // R8
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 12'h000, 12'h5A1, 2'd0, 8'd10}, // R10 wrap
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 12'h0FF, 12'h5A1, 2'd0, 8'd3},  // R3 ignored
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 12'h7B3, 12'h7B3, 2'd0, 8'd4},  // R4 and R5
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 12'h000, 12'h7B2, 2'd1, 8'd8}   // R8
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sel, adsp_n, adsc_n, adv_n, mode_lin;
    logic [AW-1:0] addr_in;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) i_burst_addr_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .adsp_n   (adsp_n),
        .adsc_n   (adsc_n),
        .adv_n    (adv_n),
        .mode_lin (mode_lin),
        .addr_in  (addr_in),
        .addr_out (addr_out),
        .beat     (beat)
    );

    task automatic check(input string tag, input logic [AW-1:0] a_act,
                         input logic [AW-1:0] a_exp, input logic [1:0] b_act,
                         input logic [1:0] b_exp);
        checks++;
        if (a_act !== a_exp || b_act !== b_exp) begin
            failures++;
            $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                     tag, a_act, b_act, a_exp, b_exp);
        end
    endtask

    task automatic idle_inputs();
        adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1; sel = 1'b0; addr_in = '0;
    endtask

    initial begin
        rst_n = 1'b0; mode_lin = 1'b0;
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1 check("R1 reset", addr_out, '0, beat, 2'd0);

        // R1: advance in idle has no effect
        @(negedge clk) adv_n = 1'b0;
        @(posedge clk); #1;
        check("R1 idle advance", addr_out, '0, beat, 2'd0);
        @(posedge clk); #1;
        check("R1 idle advance 2", addr_out, '0, beat, 2'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            adsp_n = TBL[i].adsp_n; adsc_n = TBL[i].adsc_n; sel = TBL[i].sel;
            adv_n = TBL[i].adv_n; mode_lin = TBL[i].mode; addr_in = TBL[i].addr;
            @(posedge clk); #1;
            check($sformatf("R%0d table step %0d", TBL[i].req, i),
                  addr_out, TBL[i].exp_addr, beat, TBL[i].exp_beat);
        end

        // R11: mode change lags by one edge
        @(negedge clk);
        adsp_n = 1'b1; adsc_n = 1'b0; adv_n = 1'b1; mode_lin = 1'b0; addr_in = 12'h101;
        @(posedge clk); #1;
        check("R11 load", addr_out, 12'h101, beat, 2'd0);
        @(negedge clk) begin adsc_n = 1'b1; adv_n = 1'b0; end
        @(posedge clk); #1;
        check("R11 interleaved beat1", addr_out, 12'h100, beat, 2'd1);
        @(negedge clk) begin adv_n = 1'b1; mode_lin = 1'b1; end
        #1 check("R11 before edge", addr_out, 12'h100, beat, 2'd1);
        @(posedge clk); #1;
        check("R11 after edge", addr_out, 12'h102, beat, 2'd1);

        // R5: cache strobe with advance mid-burst restarts
        @(negedge clk) begin adsc_n = 1'b0; adv_n = 1'b0; addr_in = 12'hFFE; end
        @(posedge clk); #1;
        check("R5 load over advance", addr_out, 12'hFFE, beat, 2'd0);
        @(negedge clk) adsc_n = 1'b1;
        @(posedge clk); #1;
        check("R7 linear wrap of low bits", addr_out, 12'hFFF, beat, 2'd1);
        @(posedge clk); #1;
        check("R9 upper bits held", addr_out, 12'hFFC, beat, 2'd2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule